// File: doc/BRIEF.md
# Two-Level Word-to-Pair Serializer

This block turns a parallel word of `W_IN` bits (8 by default) into a stream of bit pairs, one pair per half-rate clock cycle. It does this by halving the width again and again: the captured word becomes a bus half as wide at twice the update rate, and so on until two lanes remain. With the default width there are two halving steps, 8 to 4 and then 4 to 2. Lane 0 carries the even-numbered bit of each pair and lane 1 the odd-numbered bit. Conversion to a single full-rate line happens later, downstream of this block.

The slower rates are modelled with one half-rate clock and a phase counter, not with divided clocks. Each halving step forwards the low half of its input at once. In the same cycle it parks the high half in a hold register. The parked half is forwarded in the next slot, so the upstream stage is free to change underneath it. The block pulses a strobe in every cycle whose end samples a new word. The source keeps the word valid across that edge.

Top module: `pair_serializer`

## Requirements
- R1: `take_o` is high in the first cycle after reset is released and then once every `W_IN/2` cycles (every 4 cycles by default). It is low in all other cycles, including every cycle in which `rst` is high.
- R2: `word_i` is sampled only at the clock edge that ends a cycle with `take_o` high. Its value in any other cycle, including reset cycles, has no effect on `lane_o`.
- R3: If a word is taken in cycle c, its pair j (j = 0 .. W_IN/2-1) is on `lane_o` in cycle c+L+1+j. In that pair, `lane_o[0]` is bit 2j of the word and `lane_o[1]` is bit 2j+1. So bit 0 goes out first, on lane 0.
- R4: The latency from the take cycle to the first pair is L+1 cycles, where L = log2(W_IN/2). This is 3 cycles for the default width and 4 cycles for a 16-bit word.
- R5: The stream has no gaps. The first pair of each word follows the last pair of the previous word in the next cycle, and no pair is repeated.
- R6: Reset is synchronous and active high. From the first reset edge on, `lane_o` is 0. After release, `lane_o` stays 0 in cycles 0 through L, until the first word's data arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-rate clock; one output pair per cycle |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | W_IN | Parallel word, sampled at the end of a take cycle |
| take_o | output | 1 | High in the cycle whose end captures `word_i` |
| lane_o | output | 2 | Current pair: bit 0 even lane, bit 1 odd lane |

## Verification
The bench builds two copies side by side. One uses the default 8-bit word, which has two halving steps and a 4-cycle word period. The other uses a 16-bit word, which has three halving steps, an 8-cycle period and a 4-cycle latency. The 16-bit copy exercises the phase alignment of a middle stage that is neither the first nor the last. Both copies see all-zero, all-one, alternating, walking-one and pseudo-random words. Different junk is driven on every non-take cycle. A reset in the middle of the stream checks that the phase restarts and the output clears.

// File: rtl/pser_pkg.sv
package pser_pkg;

    // which half of its input a halving stage forwards in a given slot
    typedef enum logic {
        HALF_LOW  = 1'b0,
        HALF_HIGH = 1'b1
    } pser_half_e;

    // per-cycle control of one halving stage
    typedef struct packed {
        logic       load;
        pser_half_e half;
    } pser_ctl_t;

    // Stage k of lvl updates twice per span = 2^(lvl-k+1) cycles.
    // It takes the low half one cycle after its upstream neighbour changes,
    // and releases the parked high half span/2 cycles later.
    function automatic pser_ctl_t stage_ctl(input int unsigned ph,
                                            input int unsigned k,
                                            input int unsigned lvl);
        pser_ctl_t   c;
        int unsigned span;
        int unsigned pos;
        span   = 32'd1 << (lvl - k + 1);
        pos    = (ph + (32'd1 << lvl) - k) % span;
        c.load = (pos == 0) || (pos == span / 2);
        c.half = (pos == 0) ? HALF_LOW : HALF_HIGH;
        return c;
    endfunction

endpackage

// File: rtl/pser_phase.sv
module pser_phase #(
    parameter int LVL = 2
) (
    input  logic           clk,
    input  logic           rst,
    output logic [LVL-1:0] ph_o,
    output logic           take_o
);
    logic [LVL-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst) ph_q <= '0;
        else     ph_q <= ph_q + 1'b1;
    end

    assign ph_o   = ph_q;
    assign take_o = !rst && (ph_q == '0);
endmodule

// File: rtl/pser_capture.sv
module pser_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)         word_q <= '0;
        else if (load_i) word_q <= word_i;
    end

    assign word_o = word_q;
endmodule

// File: rtl/pser_halve.sv
module pser_halve
    import pser_pkg::*;
#(
    parameter int WO  = 4,
    parameter int K   = 1,
    parameter int LVL = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [LVL-1:0]  ph_i,
    input  logic [2*WO-1:0] src_i,
    output logic [WO-1:0]   dst_o
);
    pser_ctl_t   ctl;
    logic [WO-1:0] hold_q;
    logic [WO-1:0] out_q;

    always_comb ctl = stage_ctl(int'(ph_i), K, LVL);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            out_q  <= '0;
        end else if (ctl.load) begin
            if (ctl.half == HALF_LOW) begin
                out_q  <= src_i[WO-1:0];
                hold_q <= src_i[2*WO-1:WO];
            end else begin
                out_q  <= hold_q;
            end
        end
    end

    assign dst_o = out_q;
endmodule

// File: rtl/pair_serializer.sv
module pair_serializer #(
    parameter int W_IN = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [W_IN-1:0] word_i,
    output logic            take_o,
    output logic [1:0]      lane_o
);
    localparam int LVL = $clog2(W_IN / 2);

    logic [LVL-1:0]  ph;
    logic [W_IN-1:0] cap;

    pser_phase #(.LVL(LVL)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .ph_o   (ph),
        .take_o (take_o)
    );

    pser_capture #(.W(W_IN)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .load_i (take_o),
        .word_i (word_i),
        .word_o (cap)
    );

    for (genvar k = 1; k <= LVL; k++) begin : g_st
        localparam int WO = W_IN >> k;
        logic [2*WO-1:0] src;
        logic [WO-1:0]   dst;

        if (k == 1) begin : g_first
            assign src = cap;
        end else begin : g_next
            assign src = g_st[k-1].dst;
        end

        pser_halve #(.WO(WO), .K(k), .LVL(LVL)) u_halve (
            .clk   (clk),
            .rst   (rst),
            .ph_i  (ph),
            .src_i (src),
            .dst_o (dst)
        );
    end

    assign lane_o = g_st[LVL].dst;
endmodule

// File: rtl/pser_checker.sv
module pser_checker #(
    parameter int W_IN = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [W_IN-1:0] word_i,
    input logic            take_o,
    input logic [1:0]      lane_o
);
    localparam int N   = W_IN / 2;
    localparam int L   = $clog2(N);
    localparam int LAT = L + 1;
    localparam int AW  = $clog2(N + 1) + 1;

    logic [W_IN-1:0] sv_word, prev_word;
    logic [AW-1:0]   age;
    logic [1:0]      n_takes;

    // age == k in cycle c+k after a take in cycle c
    always_ff @(posedge clk) begin
        if (rst) begin
            sv_word   <= '0;
            prev_word <= '0;
            age       <= '0;
            n_takes   <= '0;
        end else if (take_o) begin
            prev_word <= sv_word;
            sv_word   <= word_i;
            age       <= AW'(1);
            if (n_takes != 2'd2) n_takes <= n_takes + 1'b1;
        end else if (age != '1) begin
            age <= age + 1'b1;
        end
    end

    assert_take_spacing_R1: assert property (@(posedge clk) disable iff (rst)
        take_o |=> !take_o);

    assert_take_return_R1: assert property (@(posedge clk) disable iff (rst)
        (n_takes != 2'd0 && age == AW'(N)) |-> take_o);

    assert_first_pair_R4: assert property (@(posedge clk) disable iff (rst)
        (n_takes != 2'd0 && age == AW'(LAT)) |-> (lane_o == sv_word[1:0]));

    assert_seam_R5: assert property (@(posedge clk) disable iff (rst)
        (n_takes == 2'd2 && age == AW'(L)) |-> (lane_o == prev_word[W_IN-1 -: 2]));

    assert_reset_clear_R6: assert property (@(posedge clk)
        rst |=> (lane_o == 2'b00));
endmodule

bind pair_serializer pser_checker #(.W_IN(W_IN)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .word_i (word_i),
    .take_o (take_o),
    .lane_o (lane_o)
);

// File: tb/sim_pair_serializer.sv
module sim_pair_serializer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  w0 = '0;
    logic [15:0] w1 = '0;
    logic        take0, take1;
    logic [1:0]  lane0, lane1;

    logic [7:0]  q0[$];
    logic [15:0] q1[$];
    int tests = 0;
    int fails = 0;
    int pidx  = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pair_serializer u0 (.clk(clk), .rst(rst), .word_i(w0), .take_o(take0), .lane_o(lane0));
    pair_serializer #(.W_IN(16)) u1 (.clk(clk), .rst(rst), .word_i(w1), .take_o(take1), .lane_o(lane1));

    function automatic logic [15:0] pat(input int i);
        if (i == 0)      return 16'h0000;
        else if (i == 1) return 16'hFFFF;
        else if (i == 2) return 16'h5555;
        else if (i == 3) return 16'hAAAA;
        else if (i < 20) return 16'h0001 << (i - 4);
        else             return 16'($urandom);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // expected pair for an instance with period n_w and latency lat at cycle n
    task automatic chk_lane(input string who, input int n, input int n_w, input int lat,
                            input logic [15:0] word_at_w, input logic [1:0] act);
        int m, j;
        if (n < lat) begin
            chk({who, " R6 idle after reset"}, {14'd0, act}, 16'd0);
        end else begin
            m = n - lat;
            j = m % n_w;
            if (j == 0 && m == 0)
                chk({who, " R4 first pair latency"}, {14'd0, act}, {14'd0, word_at_w[1:0]});
            else if (j == 0)
                chk({who, " R5 seamless next word"}, {14'd0, act}, {14'd0, word_at_w[1:0]});
            else
                chk({who, " R3 pair order, R2 junk ignored"}, {14'd0, act},
                    {14'd0, word_at_w[2*j +: 2]});
        end
    endtask

    task automatic run(input int cycles);
        for (int n = 0; n < cycles; n++) begin
            logic [15:0] p;
            #1;
            // R1: strobe cadence
            chk("u0 R1 take strobe", {15'd0, take0}, {15'd0, (n % 4) == 0});
            chk("u1 R1 take strobe", {15'd0, take1}, {15'd0, (n % 8) == 0});
            chk_lane("u0", n, 4, 3, (n >= 3) ? {8'd0, q0[(n - 3) / 4]} : 16'd0, lane0);
            chk_lane("u1", n, 8, 4, (n >= 4) ? q1[(n - 4) / 8] : 16'd0, lane1);
            // drive: real words on take cycles, junk otherwise (R2)
            if (n % 4 == 0) begin
                p = pat(pidx); pidx++;
                w0 = p[7:0]; q0.push_back(p[7:0]);
            end else begin
                w0 = 8'($urandom);
            end
            if (n % 8 == 0) begin
                p = pat(pidx); pidx++;
                w1 = p; q1.push_back(p);
            end else begin
                w1 = 16'($urandom);
            end
            @(negedge clk);
        end
    endtask

    task automatic hold_reset(input int cycles);
        rst = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            w0 = 8'($urandom);
            w1 = 16'($urandom);
            @(posedge clk);
            @(negedge clk);
            #1;
            chk("u0 R6 reset clears lanes", {14'd0, lane0}, 16'd0);
            chk("u1 R6 reset clears lanes", {14'd0, lane1}, 16'd0);
            chk("u0 R1 no strobe in reset", {15'd0, take0}, 16'd0);
            chk("u1 R1 no strobe in reset", {15'd0, take1}, 16'd0);
        end
        @(negedge clk);
        rst = 1'b0;
        q0.delete();
        q1.delete();
    endtask

    initial begin
        @(negedge clk);
        hold_reset(3);
        run(64);
        hold_reset(3);
        run(72);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule